// File: doc/BRIEF.md
# Binary-Field Multiplicative Inverter

This block returns the multiplicative inverse of an element of GF(2^N) in polynomial basis, reduced by a fixed irreducible polynomial. It raises the operand to the power 2^N − 2 by walking an addition chain over the bits of N−1, starting at the most significant bit. The chain keeps a running power A^(2^k − 1). A doubling step squares that value k times and multiplies the result by the value itself. An increment step squares once and multiplies by A. A final single squaring then gives the inverse.

All squaring goes through one combinational squarer that finishes in one clock. All products go through one shared multiplier with a LAT-stage pipeline. A sequencer driven by counters runs each squaring burst to its end, issues one product, and waits for that product to come back before it moves on. The caller pulses `start` with the operand on `a_in`. It then waits for the one-cycle `done` pulse and reads `inv_out`. The default field is GF(2^8) with reduction polynomial 0x11B.

Top module: `gfinv_top`

## Requirements
- R1: For every nonzero input A, the product A·inv_out reduced by the polynomial POLY equals 1 (default field GF(2^8), POLY = 0x11B; for example, the inverse of 0x53 is 0xCA and the inverse of 0x02 is 0x8D).
- R2: An input of zero produces an output of zero, and `done` is still pulsed.
- R3: One inversion performs exactly N−1 squarings, the final one included.
- R4: One inversion issues exactly floor(log2(N−1)) + HW(N−1) − 1 products, where HW is the Hamming weight. This is 4 for N = 8.
- R5: Each product returns exactly LAT cycles after it is issued, and no product is issued while another is still in the pipeline.
- R6: `done` is high for exactly one cycle. `inv_out` changes only in the cycle in which `done` rises and holds its value until the next result.
- R7: A `start` pulse that arrives while an inversion is running is ignored: the running result is not disturbed, and no extra `done` pulse follows.
- R8: After reset, `done` is low and `inv_out` is zero.
- R9: `done` rises (N−2) + M·(LAT+1) + 2 clock edges after the edge that samples `start`, whatever the value of A, where M is the product count from R4. This is 24 edges for the defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an inversion of `a_in`; accepted only when idle |
| a_in | input | N | Field element to invert, sampled with `start` |
| done | output | 1 | One-cycle pulse when `inv_out` holds the new result |
| inv_out | output | N | Inverse of the last accepted operand |

## Verification
The bench sweeps every nonzero element. A wrong reduction polynomial, a squarer that drops a reduction term, or a chain that misreads a bit of N−1 gives products other than one. Zero is fed on its own: a design that treats zero as a special case and hangs never pulses `done`. The latency is measured for every operand, so a sequencer that skips a wait or lets a squaring run go long is caught by the cycle count. A `start` pulse sent in the middle of a run checks that the result in flight survives and that no second `done` pulse follows.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SQR,
    ST_ISSUE,
    ST_WAIT,
    ST_FINAL
  } inv_state_e;
endpackage

// File: rtl/gfinv_sqr.sv
module gfinv_sqr #(
  parameter int N = 8,
  parameter logic [N:0] POLY = 9'h11B
) (
  input  logic [N-1:0] x,
  output logic [N-1:0] y
);
  localparam int PW = 2*N - 1;

  function automatic logic [N-1:0] square_mod(input logic [N-1:0] v);
    logic [PW-1:0] p;
    logic [PW-1:0] pext;
    p = '0;
    for (int i = 0; i < N; i++) p[2*i] = v[i];
    pext = {{(N-2){1'b0}}, POLY};
    for (int i = PW-1; i >= N; i--)
      if (p[i]) p = p ^ (pext << (i - N));
    return p[N-1:0];
  endfunction

  assign y = square_mod(x);
endmodule

// File: rtl/gfinv_mul.sv
module gfinv_mul #(
  parameter int N = 8,
  parameter logic [N:0] POLY = 9'h11B,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  output logic         vld,
  output logic [N-1:0] prod
);
  function automatic logic [N-1:0] mul_mod(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N-1:0] r;
    r = '0;
    for (int i = N-1; i >= 0; i--) begin
      r = {r[N-2:0], 1'b0} ^ (r[N-1] ? POLY[N-1:0] : '0);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  logic [N-1:0] pq [LAT];
  logic [LAT-1:0] vq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vq <= '0;
      for (int s = 0; s < LAT; s++) pq[s] <= '0;
    end else begin
      vq[0] <= go;
      pq[0] <= mul_mod(op_a, op_b);
      for (int s = 1; s < LAT; s++) begin
        vq[s] <= vq[s-1];
        pq[s] <= pq[s-1];
      end
    end
  end

  assign vld  = vq[LAT-1];
  assign prod = pq[LAT-1];
endmodule

// File: rtl/gfinv_top.sv
module gfinv_top
  import gfinv_pkg::*;
#(
  parameter int N = 8,
  parameter logic [N:0] POLY = 9'h11B,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] a_in,
  output logic         done,
  output logic [N-1:0] inv_out
);
  localparam int M   = N - 1;
  localparam int KW  = $clog2(M + 1);
  localparam int TOP = KW - 1;
  localparam int IW  = (TOP > 0) ? $clog2(TOP + 1) : 1;
  localparam logic [KW-1:0] MV = KW'(M);
  localparam logic [IW-1:0] IDX0 = IW'((TOP > 0) ? TOP - 1 : 0);

  inv_state_e    state;
  logic [N-1:0]  a_reg, beta, sq, res;
  logic [KW-1:0] kcnt, left;
  logic [IW-1:0] idx;
  logic          dbl, done_q;

  // named events for the checker
  logic idle, accept, sq_step, mul_issue, mul_ret;
  logic [N-1:0] sq_src, sq_y, mul_p, mul_b;
  logic [KW-1:0] k_new;

  assign idle      = (state == ST_IDLE);
  assign accept    = start && idle;
  assign sq_step   = (state == ST_SQR) || (state == ST_FINAL);
  assign mul_issue = (state == ST_ISSUE);
  assign sq_src    = (state == ST_FINAL) ? beta : sq;
  assign mul_b     = dbl ? beta : a_reg;
  assign k_new     = dbl ? (kcnt << 1) : (kcnt + 1'b1);

  gfinv_sqr #(.N(N), .POLY(POLY)) u_sqr (.x(sq_src), .y(sq_y));

  gfinv_mul #(.N(N), .POLY(POLY), .LAT(LAT)) u_mul (
    .clk(clk), .rst_n(rst_n), .go(mul_issue),
    .op_a(sq), .op_b(mul_b), .vld(mul_ret), .prod(mul_p)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      a_reg  <= '0;
      beta   <= '0;
      sq     <= '0;
      res    <= '0;
      kcnt   <= '0;
      left   <= '0;
      idx    <= '0;
      dbl    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          a_reg <= a_in;
          beta  <= a_in;
          sq    <= a_in;
          kcnt  <= KW'(1);
          left  <= KW'(1);
          idx   <= IDX0;
          dbl   <= 1'b1;
          state <= (TOP == 0) ? ST_FINAL : ST_SQR;
        end
        ST_SQR: begin
          sq <= sq_y;
          if (left == KW'(1)) state <= ST_ISSUE;
          else left <= left - 1'b1;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: if (mul_ret) begin
          beta <= mul_p;
          sq   <= mul_p;
          kcnt <= k_new;
          if (dbl && MV[idx]) begin
            dbl   <= 1'b0;
            left  <= KW'(1);
            state <= ST_SQR;
          end else if (idx == '0) begin
            state <= ST_FINAL;
          end else begin
            idx   <= idx - 1'b1;
            dbl   <= 1'b1;
            left  <= k_new;
            state <= ST_SQR;
          end
        end
        ST_FINAL: begin
          res    <= sq_y;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done    = done_q;
  assign inv_out = res;
endmodule

// File: rtl/gfinv_chk.sv
module gfinv_chk #(
  parameter int N = 8,
  parameter int LAT = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         accept,
  input logic         done,
  input logic         sq_step,
  input logic         mul_issue,
  input logic         mul_ret,
  input logic [N-1:0] inv_out
);
  localparam int M = N - 1;

  function automatic int chain_muls(input int m);
    int hw, lg;
    hw = 0; lg = -1;
    for (int i = 0; i < 32; i++) if ((m >> i) & 1) begin hw++; lg = i; end
    return lg + hw - 1;
  endfunction

  localparam int MULS = chain_muls(M);
  localparam int EXP_LAT = (N - 2) + MULS * (LAT + 1) + 2;

  int sq_cnt, mul_cnt, since_issue, lat_cnt;
  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_cnt <= 0; mul_cnt <= 0; since_issue <= 0; lat_cnt <= 0; pending <= 1'b0;
    end else begin
      if (accept) begin
        sq_cnt <= 0; mul_cnt <= 0; lat_cnt <= 1;
      end else begin
        if (sq_step) sq_cnt <= sq_cnt + 1;
        if (mul_issue) mul_cnt <= mul_cnt + 1;
        if (lat_cnt < EXP_LAT + 4) lat_cnt <= lat_cnt + 1;
      end
      if (mul_issue) since_issue <= 1;
      else if (since_issue < LAT + 4) since_issue <= since_issue + 1;
      if (mul_issue) pending <= 1'b1;
      else if (mul_ret) pending <= 1'b0;
    end
  end

  a_r3_square_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sq_cnt == M);
  a_r4_product_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> mul_cnt == MULS);
  a_r5_return_latency: assert property (@(posedge clk) disable iff (!rst_n)
    mul_ret |-> (pending && since_issue == LAT));
  a_r5_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    mul_issue |-> !pending);
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(inv_out));
  a_r9_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat_cnt == EXP_LAT);
endmodule

bind gfinv_top gfinv_chk #(.N(N), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .done(done),
  .sq_step(sq_step), .mul_issue(mul_issue), .mul_ret(mul_ret), .inv_out(inv_out)
);

// File: tb/gfinv_top_bench.sv
module gfinv_top_bench;
  localparam int N = 8;
  localparam int LAT = 3;
  localparam logic [N:0] POLY = 9'h11B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] a_in = '0;
  logic done;
  logic [N-1:0] inv_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  gfinv_top #(.N(N), .POLY(POLY), .LAT(LAT)) u_gfinv_top (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in),
    .done(done), .inv_out(inv_out)
  );

  // operand, expected inverse
  localparam logic [15:0] VEC [6] = '{
    16'h53CA, 16'hCA53, 16'h0101, 16'h028D, 16'h8D02, 16'h03F6
  };

  // bench product: full carry-less product, then long division
  function automatic logic [N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [2*N-2:0] p;
    p = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        p[i+j] = p[i+j] ^ (a[i] & b[j]);
    for (int d = 2*N-2; d >= N; d--)
      if (p[d]) for (int t = 0; t <= N; t++) p[d-N+t] = p[d-N+t] ^ POLY[t];
    return p[N-1:0];
  endfunction

  function automatic int ref_latency();
    int m, hw, lg;
    m = N - 1; hw = 0; lg = 0;
    for (int i = 0; i < 32; i++) if ((m >> i) & 1) begin hw++; lg = i; end
    return (m - 1) + (lg + hw - 1) * (LAT + 1) + 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_inv(input logic [N-1:0] a, output logic [N-1:0] r, output int lat);
    @(negedge clk);
    a_in = a; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 1000) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    r = inv_out;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r, held;
    int lat, lat_exp, extra;
    lat_exp = ref_latency();

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R8 done after reset", int'(done), 0);
    check(inv_out == '0, "R8 result after reset", int'(inv_out), 0);
    rst_n = 1'b1;

    // table of known pairs
    for (int v = 0; v < 6; v++) begin
      run_inv(VEC[v][15:8], r, lat);
      check(r == VEC[v][7:0], "R1 table vector", int'(r), int'(VEC[v][7:0]));
      check(lat == lat_exp, "R9 latency table", lat, lat_exp);
    end

    // sweep of all nonzero elements
    for (int x = 1; x < (1 << N); x++) begin
      run_inv(N'(x), r, lat);
      check(ref_mul(N'(x), r) == N'(1), "R1 product is one", int'(ref_mul(N'(x), r)), 1);
      check(lat == lat_exp, "R9 latency sweep", lat, lat_exp);
    end

    // zero input
    run_inv('0, r, lat);
    check(lat == lat_exp, "R2 zero still pulses done", lat, lat_exp);
    check(r == '0, "R2 zero maps to zero", int'(r), 0);

    // result hold and one-cycle done (R6)
    run_inv(8'h02, r, lat);
    held = inv_out;
    @(posedge clk); @(negedge clk);
    check(done == 1'b0, "R6 done is one cycle", int'(done), 0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(inv_out == held, "R6 result held", int'(inv_out), int'(held));

    // start while busy is ignored (R7)
    @(negedge clk);
    a_in = 8'h53; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (4) begin @(posedge clk); @(negedge clk); lat++; end
    a_in = 8'h07; start = 1'b1;
    @(posedge clk); @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 1000) begin @(posedge clk); @(negedge clk); lat++; end
    check(inv_out == 8'hCA, "R7 busy start ignored result", int'(inv_out), 8'hCA);
    check(lat == lat_exp, "R7 busy start ignored latency", lat, lat_exp);
    extra = 0;
    repeat (60) begin
      @(posedge clk); @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R7 no extra done", extra, 0);
    check(inv_out == 8'hCA, "R7 result kept", int'(inv_out), 8'hCA);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule